// File: doc/BRIEF.md
# Four-Wide Integer Register Rename Unit

This block renames up to four integer instructions per clock. Each instruction names up to two logical source registers and one logical destination out of 32. The unit translates these into 6-bit tags for a pool of 64 physical registers. Each source tag comes with a ready bit. A destination receives a fresh tag taken from a free-tag FIFO. The tag that the destination held before is reported so that the pipeline can carry it to graduation, where it is returned to the pool.

Instructions within one group can depend on each other. A later lane that reads a register written by an earlier lane of the same group picks up that lane's new tag, and the source is marked not ready. A busy bit per physical register tracks whether its value has been written back. A group renames only as a whole. It is held back when the free pool or the active-list budget cannot cover all of it.

Graduations update a retirement map. A recovery pulse copies that map into the speculative map, clears every busy bit, empties the active-list count and rewinds the free FIFO. After recovery the FIFO again holds every tag that the retirement map does not own.

Top module: `rename_unit`

## Requirements
- R1: Out of reset, logical register i maps to physical tag i. Source tags are looked up combinationally from the current map, and tags whose value is not pending report ready=1.
- R2: Each valid lane with a non-zero destination takes the next tag from the free FIFO, in lane order. Out of reset the FIFO holds tags 32, 33, …, 63 in that order, and no two lanes of a group receive the same tag.
- R3: `pold_o` for a lane is the tag its destination mapped to before the lane. When an earlier lane of the same group wrote that register, it is that lane's new tag.
- R4: A source that matches the destination of an earlier valid lane in the group takes the new tag of the latest such lane, with ready=0. A lane's own destination and the destinations of later lanes do not affect its sources.
- R5: Logical register 0 always yields tag 0 with ready=1. A destination of 0 allocates nothing, reports `pdst_o`=0 and `pold_o`=0, and does not count toward the free-tag need.
- R6: An allocated tag reads not ready until a writeback broadcast of that tag. A broadcast in the same cycle as a lookup already reports ready.
- R7: A graduating instruction with a non-zero destination pushes its old tag to the tail of the free FIFO. Every graduating instruction releases one active-list slot.
- R8: When free tags are fewer than the group's destinations, `ready_o` is 0 and the group changes no state.
- R9: When the in-flight count plus the group's valid lanes would exceed 32, `ready_o` is 0.
- R10: While `recover_i` is high, `ready_o` is 0. The next cycle, the map equals the retirement map, all tags read ready, the in-flight count is 0, and allocation resumes with the oldest tag not held by the retirement map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lane_vld_i | input | 4 | Lane holds an instruction |
| src_a_i | input | 4x5 | First logical source per lane |
| src_b_i | input | 4x5 | Second logical source per lane |
| dst_i | input | 4x5 | Logical destination per lane (0 = none) |
| ready_o | output | 1 | Group is accepted at this clock edge |
| tag_a_o | output | 4x6 | Physical tag of first source |
| tag_b_o | output | 4x6 | Physical tag of second source |
| rdy_a_o | output | 4 | First source value available |
| rdy_b_o | output | 4 | Second source value available |
| pdst_o | output | 4x6 | Newly allocated destination tag |
| pold_o | output | 4x6 | Previous tag of destination |
| wb_vld_i | input | 2 | Writeback broadcast valid |
| wb_tag_i | input | 2x6 | Writeback broadcast tag |
| grad_vld_i | input | 4 | Instruction graduates in this slot |
| grad_dst_i | input | 4 | Graduating instruction has a destination |
| grad_ldst_i | input | 4x5 | Logical destination of graduating instruction |
| grad_pdst_i | input | 4x6 | Its physical destination tag |
| grad_pold_i | input | 4x6 | Its previous tag, to be freed |
| recover_i | input | 1 | Restore from the retirement map |

## Verification
The bench uses the default parameters: four lanes, 32 logical and 64 physical registers, a 32-deep active-list budget and two writeback ports. With these values the free pool and the active list are both exactly 32. Driving one of them to exhaustion on its own therefore needs destination-free instructions, which fill the active list and then graduate without returning tags. These defaults also make the FIFO wrap, and a graduated tag is handed out again before recovery rewinds the pointer.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned RN_LANES    = 4;
  localparam int unsigned RN_NUM_LOG  = 32;
  localparam int unsigned RN_NUM_PHYS = 64;
  localparam int unsigned RN_AL_DEPTH = 32;
  localparam int unsigned RN_NUM_WB   = 2;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int unsigned LANES    = 4,
  parameter int unsigned NUM_LOG  = 32,
  parameter int unsigned NUM_PHYS = 64,
  localparam int unsigned LW  = $clog2(NUM_LOG),
  localparam int unsigned TW  = $clog2(NUM_PHYS),
  localparam int unsigned NRD = 3 * LANES
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NRD-1:0][LW-1:0]     rd_addr_i,
  output logic [NRD-1:0][TW-1:0]     rd_tag_o,
  input  logic [LANES-1:0]           wr_i,
  input  logic [LANES-1:0][LW-1:0]   wr_addr_i,
  input  logic [LANES-1:0][TW-1:0]   wr_tag_i,
  input  logic [LANES-1:0]           ret_i,
  input  logic [LANES-1:0][LW-1:0]   ret_addr_i,
  input  logic [LANES-1:0][TW-1:0]   ret_tag_i,
  input  logic                       recover_i
);
  logic [TW-1:0] spec_q [NUM_LOG];
  logic [TW-1:0] ret_q  [NUM_LOG];
  logic [TW-1:0] ret_nxt[NUM_LOG];

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_tag_o[r] = spec_q[rd_addr_i[r]];
  end

  // later graduating lane wins on equal logical register
  always_comb begin
    for (int i = 0; i < NUM_LOG; i++) ret_nxt[i] = ret_q[i];
    for (int k = 0; k < LANES; k++)
      if (ret_i[k]) ret_nxt[ret_addr_i[k]] = ret_tag_i[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_LOG; i++) begin
        spec_q[i] <= TW'(i);
        ret_q[i]  <= TW'(i);
      end
    end else begin
      for (int i = 0; i < NUM_LOG; i++) ret_q[i] <= ret_nxt[i];
      if (recover_i) begin
        for (int i = 0; i < NUM_LOG; i++) spec_q[i] <= ret_nxt[i];
      end else begin
        for (int k = 0; k < LANES; k++)
          if (wr_i[k]) spec_q[wr_addr_i[k]] <= wr_tag_i[k];
      end
    end
  end
endmodule

// File: rtl/rn_free_list.sv
// Circular FIFO of free tags. DEPTH must be a power of two.
// Invariant: tail - retire_head == DEPTH, so recovery rewinds head to retire_head.
module rn_free_list #(
  parameter int unsigned LANES    = 4,
  parameter int unsigned NUM_LOG  = 32,
  parameter int unsigned NUM_PHYS = 64,
  localparam int unsigned TW    = $clog2(NUM_PHYS),
  localparam int unsigned DEPTH = NUM_PHYS - NUM_LOG,
  localparam int unsigned IW    = $clog2(DEPTH),
  localparam int unsigned PW    = IW + 1,
  localparam int unsigned CW    = $clog2(LANES) + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [CW-1:0]             pop_cnt_i,
  output logic [LANES-1:0][TW-1:0]  peek_o,
  output logic [PW-1:0]             cnt_o,
  input  logic [LANES-1:0]          push_i,
  input  logic [LANES-1:0][TW-1:0]  push_tag_i,
  input  logic                      recover_i
);
  logic [TW-1:0] mem_q [DEPTH];
  logic [PW-1:0] head_q, tail_q, rhead_q;
  logic [LANES-1:0][IW-1:0] slot;
  logic [CW-1:0] npush;

  for (genvar k = 0; k < LANES; k++) begin : g_peek
    assign peek_o[k] = mem_q[head_q[IW-1:0] + IW'(k)];
  end

  always_comb begin
    npush = '0;
    for (int k = 0; k < LANES; k++) begin
      slot[k] = tail_q[IW-1:0] + IW'(npush);
      npush   = npush + CW'(push_i[k]);
    end
  end

  assign cnt_o = tail_q - head_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= TW'(NUM_LOG + i);
      head_q  <= '0;
      tail_q  <= PW'(DEPTH);
      rhead_q <= '0;
    end else begin
      for (int k = 0; k < LANES; k++)
        if (push_i[k]) mem_q[slot[k]] <= push_tag_i[k];
      tail_q  <= tail_q + PW'(npush);
      rhead_q <= rhead_q + PW'(npush);
      head_q  <= recover_i ? rhead_q + PW'(npush) : head_q + PW'(pop_cnt_i);
    end
  end
endmodule

// File: rtl/rn_busy_table.sv
module rn_busy_table #(
  parameter int unsigned LANES    = 4,
  parameter int unsigned NUM_PHYS = 64,
  parameter int unsigned NUM_WB   = 2,
  localparam int unsigned TW = $clog2(NUM_PHYS),
  localparam int unsigned NQ = 2 * LANES
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [LANES-1:0]           set_i,
  input  logic [LANES-1:0][TW-1:0]   set_tag_i,
  input  logic [NUM_WB-1:0]          wb_i,
  input  logic [NUM_WB-1:0][TW-1:0]  wb_tag_i,
  input  logic                       clear_all_i,
  input  logic [NQ-1:0][TW-1:0]      q_tag_i,
  output logic [NQ-1:0]              q_rdy_o
);
  logic [NUM_PHYS-1:0] busy_q;

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      q_rdy_o[q] = !busy_q[q_tag_i[q]];
      for (int w = 0; w < NUM_WB; w++)
        if (wb_i[w] && wb_tag_i[w] == q_tag_i[q]) q_rdy_o[q] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
    end else if (clear_all_i) begin
      busy_q <= '0;
    end else begin
      for (int w = 0; w < NUM_WB; w++)
        if (wb_i[w]) busy_q[wb_tag_i[w]] <= 1'b0;
      for (int k = 0; k < LANES; k++)
        if (set_i[k]) busy_q[set_tag_i[k]] <= 1'b1;
    end
  end
endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
  parameter int unsigned LANES    = rn_pkg::RN_LANES,
  parameter int unsigned NUM_LOG  = rn_pkg::RN_NUM_LOG,
  parameter int unsigned NUM_PHYS = rn_pkg::RN_NUM_PHYS,
  parameter int unsigned AL_DEPTH = rn_pkg::RN_AL_DEPTH,
  parameter int unsigned NUM_WB   = rn_pkg::RN_NUM_WB,
  localparam int unsigned LW = $clog2(NUM_LOG),
  localparam int unsigned TW = $clog2(NUM_PHYS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [LANES-1:0]           lane_vld_i,
  input  logic [LANES-1:0][LW-1:0]   src_a_i,
  input  logic [LANES-1:0][LW-1:0]   src_b_i,
  input  logic [LANES-1:0][LW-1:0]   dst_i,
  output logic                       ready_o,
  output logic [LANES-1:0][TW-1:0]   tag_a_o,
  output logic [LANES-1:0][TW-1:0]   tag_b_o,
  output logic [LANES-1:0]           rdy_a_o,
  output logic [LANES-1:0]           rdy_b_o,
  output logic [LANES-1:0][TW-1:0]   pdst_o,
  output logic [LANES-1:0][TW-1:0]   pold_o,
  input  logic [NUM_WB-1:0]          wb_vld_i,
  input  logic [NUM_WB-1:0][TW-1:0]  wb_tag_i,
  input  logic [LANES-1:0]           grad_vld_i,
  input  logic [LANES-1:0]           grad_dst_i,
  input  logic [LANES-1:0][LW-1:0]   grad_ldst_i,
  input  logic [LANES-1:0][TW-1:0]   grad_pdst_i,
  input  logic [LANES-1:0][TW-1:0]   grad_pold_i,
  input  logic                       recover_i
);
  localparam int unsigned CW    = $clog2(LANES) + 1;
  localparam int unsigned OW    = $clog2(LANES);
  localparam int unsigned DEPTH = NUM_PHYS - NUM_LOG;
  localparam int unsigned PW    = $clog2(DEPTH) + 1;
  localparam int unsigned AW    = $clog2(AL_DEPTH + LANES) + 1;

  logic [3*LANES-1:0][LW-1:0] map_addr;
  logic [3*LANES-1:0][TW-1:0] map_tag;
  logic [2*LANES-1:0][TW-1:0] bq_tag;
  logic [2*LANES-1:0]         bq_rdy;
  logic [LANES-1:0][TW-1:0]   fl_peek;
  logic [PW-1:0]              fl_cnt;
  logic [LANES-1:0]           need, alloc, gfree;
  logic [LANES-1:0][CW-1:0]   off;
  logic [CW-1:0]              nneed, nvld, ngrad;
  logic [AW-1:0]              al_q;
  logic                       fire;

  // lane accounting
  always_comb begin
    nneed = '0;
    nvld  = '0;
    ngrad = '0;
    for (int k = 0; k < LANES; k++) begin
      need[k]  = lane_vld_i[k] && (dst_i[k] != '0);
      off[k]   = nneed;
      nneed    = nneed + CW'(need[k]);
      nvld     = nvld + CW'(lane_vld_i[k]);
      ngrad    = ngrad + CW'(grad_vld_i[k]);
      gfree[k] = grad_vld_i[k] && grad_dst_i[k] && (grad_ldst_i[k] != '0);
    end
  end

  assign ready_o = !recover_i && (fl_cnt >= PW'(nneed)) &&
                   ((al_q + AW'(nvld)) <= AW'(AL_DEPTH));
  assign fire    = ready_o;
  assign alloc   = fire ? need : '0;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign map_addr[k]           = src_a_i[k];
    assign map_addr[LANES+k]     = src_b_i[k];
    assign map_addr[2*LANES+k]   = dst_i[k];
    assign bq_tag[k]             = map_tag[k];
    assign bq_tag[LANES+k]       = map_tag[LANES+k];
    assign pdst_o[k] = need[k] ? fl_peek[off[k][OW-1:0]] : '0;
  end

  // intra-group dependency resolution: latest earlier writer wins
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      tag_a_o[k] = map_tag[k];
      rdy_a_o[k] = bq_rdy[k];
      tag_b_o[k] = map_tag[LANES+k];
      rdy_b_o[k] = bq_rdy[LANES+k];
      pold_o[k]  = map_tag[2*LANES+k];
      for (int j = 0; j < LANES; j++) begin
        if (j < k && need[j]) begin
          if (dst_i[j] == src_a_i[k]) begin
            tag_a_o[k] = pdst_o[j];
            rdy_a_o[k] = 1'b0;
          end
          if (dst_i[j] == src_b_i[k]) begin
            tag_b_o[k] = pdst_o[j];
            rdy_b_o[k] = 1'b0;
          end
          if (dst_i[j] == dst_i[k]) pold_o[k] = pdst_o[j];
        end
      end
      if (src_a_i[k] == '0) begin
        tag_a_o[k] = '0;
        rdy_a_o[k] = 1'b1;
      end
      if (src_b_i[k] == '0) begin
        tag_b_o[k] = '0;
        rdy_b_o[k] = 1'b1;
      end
      if (!need[k]) pold_o[k] = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        al_q <= '0;
    else if (recover_i) al_q <= '0;
    else                al_q <= al_q + AW'(fire ? nvld : '0) - AW'(ngrad);
  end

  rn_map_table #(
    .LANES(LANES), .NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)
  ) u_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_addr_i  (map_addr),
    .rd_tag_o   (map_tag),
    .wr_i       (alloc),
    .wr_addr_i  (dst_i),
    .wr_tag_i   (pdst_o),
    .ret_i      (gfree),
    .ret_addr_i (grad_ldst_i),
    .ret_tag_i  (grad_pdst_i),
    .recover_i  (recover_i)
  );

  rn_free_list #(
    .LANES(LANES), .NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)
  ) u_free (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pop_cnt_i  (fire ? nneed : '0),
    .peek_o     (fl_peek),
    .cnt_o      (fl_cnt),
    .push_i     (gfree),
    .push_tag_i (grad_pold_i),
    .recover_i  (recover_i)
  );

  rn_busy_table #(
    .LANES(LANES), .NUM_PHYS(NUM_PHYS), .NUM_WB(NUM_WB)
  ) u_busy (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (alloc),
    .set_tag_i   (pdst_o),
    .wb_i        (wb_vld_i),
    .wb_tag_i    (wb_tag_i),
    .clear_all_i (recover_i),
    .q_tag_i     (bq_tag),
    .q_rdy_o     (bq_rdy)
  );
endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
  parameter int unsigned LANES    = 4,
  parameter int unsigned NUM_LOG  = 32,
  parameter int unsigned NUM_PHYS = 64,
  parameter int unsigned AL_DEPTH = 32,
  localparam int unsigned LW    = $clog2(NUM_LOG),
  localparam int unsigned TW    = $clog2(NUM_PHYS),
  localparam int unsigned DEPTH = NUM_PHYS - NUM_LOG,
  localparam int unsigned PW    = $clog2(DEPTH) + 1,
  localparam int unsigned AW    = $clog2(AL_DEPTH + LANES) + 1
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     ready_o,
  input logic                     recover_i,
  input logic [LANES-1:0]         lane_vld_i,
  input logic [LANES-1:0][LW-1:0] src_a_i,
  input logic [LANES-1:0][LW-1:0] dst_i,
  input logic [LANES-1:0][TW-1:0] tag_a_o,
  input logic [LANES-1:0]         rdy_a_o,
  input logic [LANES-1:0][TW-1:0] pdst_o,
  input logic [PW-1:0]            fl_cnt,
  input logic [AW-1:0]            al_q
);
  logic dup;
  int unsigned need_cnt;

  always_comb begin
    dup      = 1'b0;
    need_cnt = 0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_vld_i[i] && dst_i[i] != '0) need_cnt++;
      for (int j = i + 1; j < LANES; j++)
        if (lane_vld_i[i] && lane_vld_i[j] && dst_i[i] != '0 && dst_i[j] != '0 &&
            pdst_o[i] == pdst_o[j]) dup = 1'b1;
    end
  end

  a_r2_unique_tags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !dup);

  a_r2_free_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_cnt <= PW'(DEPTH));

  a_r8_stall_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(fl_cnt) < need_cnt) |-> !ready_o);

  a_r9_al_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    al_q <= AW'(AL_DEPTH));

  a_r10_refill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_i |=> (fl_cnt == PW'(DEPTH)));

  for (genvar k = 0; k < LANES; k++) begin : g_zero
    a_r5_zero_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_a_i[k] == '0) |-> (tag_a_o[k] == '0 && rdy_a_o[k]));
  end
endmodule

bind rename_unit rename_unit_chk #(
  .LANES(LANES), .NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS), .AL_DEPTH(AL_DEPTH)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ready_o    (ready_o),
  .recover_i  (recover_i),
  .lane_vld_i (lane_vld_i),
  .src_a_i    (src_a_i),
  .dst_i      (dst_i),
  .tag_a_o    (tag_a_o),
  .rdy_a_o    (rdy_a_o),
  .pdst_o     (pdst_o),
  .fl_cnt     (fl_cnt),
  .al_q       (al_q)
);

// File: tb/rename_unit_tb.sv
`timescale 1ns/1ps
module rename_unit_tb;
  localparam int L = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [L-1:0]       lane_vld_i;
  logic [L-1:0][4:0]  src_a_i, src_b_i, dst_i;
  logic               ready_o;
  logic [L-1:0][5:0]  tag_a_o, tag_b_o, pdst_o, pold_o;
  logic [L-1:0]       rdy_a_o, rdy_b_o;
  logic [1:0]         wb_vld_i;
  logic [1:0][5:0]    wb_tag_i;
  logic [L-1:0]       grad_vld_i, grad_dst_i;
  logic [L-1:0][4:0]  grad_ldst_i;
  logic [L-1:0][5:0]  grad_pdst_i, grad_pold_i;
  logic               recover_i;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  rename_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .lane_vld_i(lane_vld_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .dst_i(dst_i), .ready_o(ready_o),
    .tag_a_o(tag_a_o), .tag_b_o(tag_b_o), .rdy_a_o(rdy_a_o), .rdy_b_o(rdy_b_o),
    .pdst_o(pdst_o), .pold_o(pold_o), .wb_vld_i(wb_vld_i), .wb_tag_i(wb_tag_i),
    .grad_vld_i(grad_vld_i), .grad_dst_i(grad_dst_i), .grad_ldst_i(grad_ldst_i),
    .grad_pdst_i(grad_pdst_i), .grad_pold_i(grad_pold_i), .recover_i(recover_i)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    lane_vld_i = '0; src_a_i = '0; src_b_i = '0; dst_i = '0;
    wb_vld_i = '0; wb_tag_i = '0; recover_i = 1'b0;
    grad_vld_i = '0; grad_dst_i = '0; grad_ldst_i = '0;
    grad_pdst_i = '0; grad_pold_i = '0;
  endtask

  task automatic lane(int l, logic v, int a, int b, int d);
    lane_vld_i[l] = v; src_a_i[l] = 5'(a); src_b_i[l] = 5'(b); dst_i[l] = 5'(d);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    idle();
  endtask

  task automatic t_reset();
    idle();
    lane(0, 0, 1, 0, 0); lane(1, 0, 2, 0, 0); lane(2, 0, 3, 0, 0); lane(3, 0, 31, 0, 0);
    settle();
    chk("R1 src 1", int'(tag_a_o[0]), 1);
    chk("R1 src 2", int'(tag_a_o[1]), 2);
    chk("R1 src 3", int'(tag_a_o[2]), 3);
    chk("R1 src 31", int'(tag_a_o[3]), 31);
    chk("R1 ready bits", int'(rdy_a_o), 15);
    chk("R5 src0 ready", int'(rdy_b_o), 15);
    chk("R1 ready_o", int'(ready_o), 1);
    idle();
  endtask

  task automatic t_group();
    lane(0, 1, 5, 0, 5); lane(1, 1, 5, 0, 6); lane(2, 1, 6, 7, 7); lane(3, 1, 5, 7, 5);
    settle();
    chk("R2 pdst0", int'(pdst_o[0]), 32);
    chk("R2 pdst1", int'(pdst_o[1]), 33);
    chk("R2 pdst2", int'(pdst_o[2]), 34);
    chk("R2 pdst3", int'(pdst_o[3]), 35);
    chk("R3 pold0", int'(pold_o[0]), 5);
    chk("R3 pold2", int'(pold_o[2]), 7);
    chk("R3 pold3 same-group", int'(pold_o[3]), 32);
    chk("R4 own dst ignored tag", int'(tag_a_o[0]), 5);
    chk("R4 own dst ignored rdy", int'(rdy_a_o[0]), 1);
    chk("R4 lane1 bypass", int'(tag_a_o[1]), 32);
    chk("R4 lane1 not ready", int'(rdy_a_o[1]), 0);
    chk("R4 lane2 a", int'(tag_a_o[2]), 33);
    chk("R4 lane2 b own dst", int'(tag_b_o[2]), 7);
    chk("R4 lane3 a", int'(tag_a_o[3]), 32);
    chk("R4 lane3 b", int'(tag_b_o[3]), 34);
    chk("R4 lane3 b rdy", int'(rdy_b_o[3]), 0);
    chk("R2 ready_o", int'(ready_o), 1);
    step();
  endtask

  task automatic t_busy_wb();
    lane(0, 0, 5, 0, 0); lane(1, 0, 6, 0, 0); lane(2, 0, 7, 0, 0);
    settle();
    chk("R6 map 5", int'(tag_a_o[0]), 35);
    chk("R6 map 6", int'(tag_a_o[1]), 33);
    chk("R6 map 7", int'(tag_a_o[2]), 34);
    chk("R6 busy", int'(rdy_a_o[2:0]), 0);
    wb_vld_i[1] = 1'b1; wb_tag_i[1] = 6'd35;
    settle();
    chk("R6 wb same cycle", int'(rdy_a_o[0]), 1);
    step();
    lane(0, 0, 5, 0, 0); lane(1, 0, 6, 0, 0);
    settle();
    chk("R6 cleared", int'(rdy_a_o[0]), 1);
    chk("R6 other busy", int'(rdy_a_o[1]), 0);
    idle();
  endtask

  task automatic t_zero_dst();
    lane(0, 1, 0, 0, 0); lane(1, 1, 9, 0, 9);
    settle();
    chk("R5 pdst zero", int'(pdst_o[0]), 0);
    chk("R5 pold zero", int'(pold_o[0]), 0);
    chk("R5 next tag", int'(pdst_o[1]), 36);
    chk("R5 pold lane1", int'(pold_o[1]), 9);
    step();
  endtask

  task automatic t_al_full();
    // in flight: 6
    for (int g = 0; g < 6; g++) begin
      for (int l = 0; l < L; l++) lane(l, 1, 1, 2, 0);
      settle();
      chk("R9 room", int'(ready_o), 1);
      step();
    end
    for (int l = 0; l < L; l++) lane(l, 1, 1, 2, 0);
    settle();
    chk("R9 over by 2", int'(ready_o), 0);
    idle();
    lane(0, 1, 1, 2, 0); lane(1, 1, 1, 2, 0);
    settle();
    chk("R9 exact fit", int'(ready_o), 1);
    step();
    lane(0, 1, 1, 2, 0);
    settle();
    chk("R9 full", int'(ready_o), 0);
    idle();
    for (int g = 0; g < 8; g++) begin
      grad_vld_i = '1;
      step();
    end
    lane(0, 1, 1, 2, 0);
    settle();
    chk("R7 slots released", int'(ready_o), 1);
    idle();
  endtask

  task automatic t_free_short();
    for (int g = 0; g < 6; g++) begin
      for (int l = 0; l < L; l++) lane(l, 1, 1, 0, 10 + l);
      settle();
      chk("R2 fifo order", int'(pdst_o[g % L]), 37 + g * 4 + g % L);
      step();
    end
    for (int l = 0; l < L; l++) lane(l, 1, 1, 0, 20 + l);
    settle();
    chk("R8 short by one", int'(ready_o), 0);
    idle();
    @(posedge clk_i);
    @(negedge clk_i);
    lane(0, 1, 1, 0, 20); lane(1, 1, 1, 0, 21); lane(2, 1, 1, 0, 22); lane(3, 1, 1, 0, 0);
    settle();
    chk("R8 exact fit", int'(ready_o), 1);
    chk("R8 stall kept tag", int'(pdst_o[0]), 61);
    chk("R2 last tag", int'(pdst_o[2]), 63);
    step();
    lane(0, 1, 1, 0, 23);
    settle();
    chk("R8 empty", int'(ready_o), 0);
    idle();
    lane(0, 1, 22, 0, 0);
    settle();
    chk("R5 no need no stall", int'(ready_o), 1);
    chk("R8 map after stall", int'(tag_a_o[0]), 63);
    idle();
  endtask

  task automatic t_grad_free();
    grad_vld_i[0] = 1'b1; grad_dst_i[0] = 1'b1; grad_ldst_i[0] = 5'd5;
    grad_pdst_i[0] = 6'd32; grad_pold_i[0] = 6'd5;
    grad_vld_i[1] = 1'b1;
    step();
    lane(0, 1, 1, 0, 14);
    settle();
    chk("R7 freed tag ready", int'(ready_o), 1);
    chk("R7 freed tag reused", int'(pdst_o[0]), 5);
    step();
  endtask

  task automatic t_recover();
    recover_i = 1'b1;
    lane(0, 1, 1, 0, 0);
    settle();
    chk("R10 blocked", int'(ready_o), 0);
    step();
    lane(0, 0, 5, 0, 0); lane(1, 0, 6, 0, 0); lane(2, 0, 20, 0, 0); lane(3, 0, 10, 14, 0);
    settle();
    chk("R10 retired map", int'(tag_a_o[0]), 32);
    chk("R10 spec undone 6", int'(tag_a_o[1]), 6);
    chk("R10 spec undone 20", int'(tag_a_o[2]), 20);
    chk("R10 spec undone 14", int'(tag_b_o[3]), 14);
    chk("R10 all ready", int'(rdy_a_o), 15);
    idle();
    for (int l = 0; l < L; l++) lane(l, 1, 0, 0, 0);
    lane(0, 1, 15, 0, 15);
    settle();
    chk("R10 al empty", int'(ready_o), 1);
    chk("R10 fifo rewound", int'(pdst_o[0]), 33);
    chk("R10 pold", int'(pold_o[0]), 15);
    step();
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_group();
    t_busy_wb();
    t_zero_dst();
    t_al_full();
    t_free_short();
    t_grad_free();
    t_recover();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule